// File: doc/BRIEF.md
# TLB Replacement and Lockdown Controller

This block chooses which entry is replaced next in each of two 64-entry translation lookaside buffers, one serving data accesses and one serving instruction fetches. Each buffer has its own lockdown register. The register holds a reload base, the current victim pointer and a preserve bit. A single register port reaches both registers, and a one-bit selector picks which one. Software locks the lowest entries of a buffer by raising the base. The victim counter steps upward through the entries, and after it leaves the last entry it reloads the base instead of zero, so entries below the base are not replaced again.

A table-walk refill strobe for a buffer tells the block that the entry at the current victim index is being loaded. The block records the register's preserve bit against that entry and then advances the pointer. When an invalidate-all command arrives for a buffer, the block returns, in the same cycle, a per-entry mask of valid bits to clear. The mask leaves out every entry that was loaded while the preserve bit was set. The tag and data arrays, the walker and the address match logic sit outside this block.

Top module: `tlb_lock_ctrl`

## Requirements
- R1: After reset, both registers read as all zeros, both victim outputs are 0, every preserve flag is clear, and both clear masks are 0.
- R2: When `reg_sel` is 0 the port reaches the data-side register, and when it is 1 the port reaches the instruction-side register. A write to one side leaves the other side unchanged.
- R3: The register word carries the base in bits [31:26], the victim pointer in bits [25:20] and the preserve bit in bit 0. Reads return zero in bits [19:1]. Write data in bits [19:1] is ignored. A write loads base, victim and preserve bit together, and the new values are visible from the next cycle.
- R4: Each cycle in which a side's refill strobe is high, that side's victim pointer rises by exactly one. In every other cycle without a write to that side, the pointer holds.
- R5: A refill taken while the pointer is 63 reloads the pointer with the base value, not with 0.
- R6: When a write and a refill reach the same side in the same cycle, the written victim value wins. The preserve flag is still captured at the old victim index, using the old preserve bit.
- R7: A victim value written below the base still counts up to 63 before wrapping to the base. After the wrap, entries below the base are never offered again.
- R8: On a refill, the preserve flag of the entry at the current victim index takes the side's preserve bit. While a side's invalidate-all input is high, its clear mask has bit k set exactly when entry k is not preserved. At all other times the mask is zero.
- R9: Invalidate-all changes neither the preserve flags, nor the base, nor the victim pointer, and it does not affect the other side's mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register selector: 0 data side, 1 instruction side |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write word |
| reg_rdata | output | 32 | Read word of the selected register |
| refill_d | input | 1 | Data-side table-walk refill strobe |
| refill_i | input | 1 | Instruction-side table-walk refill strobe |
| inval_d | input | 1 | Data-side invalidate-all |
| inval_i | input | 1 | Instruction-side invalidate-all |
| victim_d | output | 6 | Data-side entry index to load on the next refill |
| victim_i | output | 6 | Instruction-side entry index to load on the next refill |
| clr_mask_d | output | 64 | Data-side valid-clear mask |
| clr_mask_i | output | 64 | Instruction-side valid-clear mask |

## Verification
Register writes and refill steps act at the clock edge that samples them. Their results appear on `reg_rdata` and the victim outputs one cycle later. The bench drives each strobe on a falling edge and reads the outcome just after the next falling edge. The clear masks are combinational and valid in the same cycle as the invalidate input, so the bench raises the invalidate input and samples the mask a short delay later, before any rising edge. A bench-side model of pointer, base, preserve bit and per-entry flags supplies every expected value.

// File: rtl/tlb_lock_pkg.sv
package tlb_lock_pkg;
    typedef enum logic {
        SIDE_DATA = 1'b0,
        SIDE_INSN = 1'b1
    } tlb_side_e;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned NUM_SIDE = 2;
endpackage

// File: rtl/tlb_victim_ctr.sv
module tlb_victim_ctr #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_base,
    input  logic [IDX_W-1:0] wr_victim,
    input  logic             wr_p,
    input  logic             refill,
    output logic [IDX_W-1:0] base_o,
    output logic [IDX_W-1:0] victim_o,
    output logic             p_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] base_q, victim_q, victim_step;
    logic             p_q;

    always_comb begin
        victim_step = (victim_q == LAST_IDX) ? base_q : victim_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            victim_q <= '0;
            p_q      <= 1'b0;
        end else if (wr_en) begin
            base_q   <= wr_base;
            victim_q <= wr_victim;
            p_q      <= wr_p;
        end else if (refill) begin
            victim_q <= victim_step;
        end
    end

    assign base_o   = base_q;
    assign victim_o = victim_q;
    assign p_o      = p_q;
endmodule

// File: rtl/tlb_preserve_map.sv
module tlb_preserve_map #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [IDX_W-1:0]   load_idx,
    input  logic               load_p,
    input  logic               inval,
    output logic [ENTRIES-1:0] clr_mask
);
    logic [ENTRIES-1:0] keep_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q <= '0;
        end else if (load) begin
            keep_q[load_idx] <= load_p;
        end
    end

    always_comb begin
        clr_mask = inval ? ~keep_q : '0;
    end
endmodule

// File: rtl/tlb_lock_ctrl.sv
module tlb_lock_ctrl
    import tlb_lock_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               refill_d,
    input  logic               refill_i,
    input  logic               inval_d,
    input  logic               inval_i,
    output logic [IDX_W-1:0]   victim_d,
    output logic [IDX_W-1:0]   victim_i,
    output logic [ENTRIES-1:0] clr_mask_d,
    output logic [ENTRIES-1:0] clr_mask_i
);
    localparam int unsigned BASE_LSB = WORD_W - IDX_W;
    localparam int unsigned VICT_LSB = BASE_LSB - IDX_W;
    localparam int unsigned GAP_W    = VICT_LSB - 1;

    logic [IDX_W-1:0]   base_w   [NUM_SIDE];
    logic [IDX_W-1:0]   victim_w [NUM_SIDE];
    logic               p_w      [NUM_SIDE];
    logic [ENTRIES-1:0] mask_w   [NUM_SIDE];
    logic [NUM_SIDE-1:0] refill_v, inval_v;
    logic               wdata_unused;

    assign refill_v     = {refill_i, refill_d};
    assign inval_v      = {inval_i, inval_d};
    assign wdata_unused = ^reg_wdata[VICT_LSB-1:1];

    for (genvar s = 0; s < NUM_SIDE; s++) begin : g_side
        tlb_victim_ctr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (reg_wr && (reg_sel == 1'(s))),
            .wr_base   (reg_wdata[BASE_LSB +: IDX_W]),
            .wr_victim (reg_wdata[VICT_LSB +: IDX_W]),
            .wr_p      (reg_wdata[0]),
            .refill    (refill_v[s]),
            .base_o    (base_w[s]),
            .victim_o  (victim_w[s]),
            .p_o       (p_w[s])
        );

        tlb_preserve_map #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_keep (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (refill_v[s]),
            .load_idx (victim_w[s]),
            .load_p   (p_w[s]),
            .inval    (inval_v[s]),
            .clr_mask (mask_w[s])
        );
    end

    always_comb begin
        unique case (tlb_side_e'(reg_sel))
            SIDE_DATA: reg_rdata = {base_w[0], victim_w[0], GAP_W'(0), p_w[0]};
            SIDE_INSN: reg_rdata = {base_w[1], victim_w[1], GAP_W'(0), p_w[1]};
            default:   reg_rdata = '0;
        endcase
    end

    assign victim_d   = victim_w[0];
    assign victim_i   = victim_w[1];
    assign clr_mask_d = mask_w[0];
    assign clr_mask_i = mask_w[1];
endmodule

// File: rtl/tlb_lock_chk.sv
module tlb_lock_chk #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_sel,
    input logic               reg_wr,
    input logic               refill_d,
    input logic               refill_i,
    input logic               inval_d,
    input logic               inval_i,
    input logic [IDX_W-1:0]   victim_d,
    input logic [IDX_W-1:0]   victim_i,
    input logic [IDX_W-1:0]   base_d,
    input logic [IDX_W-1:0]   base_i,
    input logic [ENTRIES-1:0] mask_d,
    input logic [ENTRIES-1:0] mask_i
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic wr_d, wr_i;
    assign wr_d = reg_wr && !reg_sel;
    assign wr_i = reg_wr && reg_sel;

    AST_STEP_D: assert property (@(posedge clk) disable iff (!rst_n)
        refill_d && !wr_d && victim_d != LAST_IDX |=> victim_d == IDX_W'($past(victim_d) + 1'b1)); // R4
    AST_STEP_I: assert property (@(posedge clk) disable iff (!rst_n)
        refill_i && !wr_i && victim_i != LAST_IDX |=> victim_i == IDX_W'($past(victim_i) + 1'b1)); // R4
    AST_HOLD_D: assert property (@(posedge clk) disable iff (!rst_n)
        !refill_d && !wr_d |=> $stable(victim_d)); // R4
    AST_WRAP_D: assert property (@(posedge clk) disable iff (!rst_n)
        refill_d && !wr_d && victim_d == LAST_IDX |=> victim_d == $past(base_d)); // R5
    AST_WRAP_I: assert property (@(posedge clk) disable iff (!rst_n)
        refill_i && !wr_i && victim_i == LAST_IDX |=> victim_i == $past(base_i)); // R5
    AST_MASK_IDLE_D: assert property (@(posedge clk) disable iff (!rst_n)
        !inval_d |-> mask_d == '0); // R8
    AST_MASK_IDLE_I: assert property (@(posedge clk) disable iff (!rst_n)
        !inval_i |-> mask_i == '0); // R8
    AST_INVAL_KEEPS_D: assert property (@(posedge clk) disable iff (!rst_n)
        inval_d && !refill_d && !wr_d |=> $stable(victim_d) && $stable(base_d)); // R9
endmodule

bind tlb_lock_ctrl tlb_lock_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_sel  (reg_sel),
    .reg_wr   (reg_wr),
    .refill_d (refill_d),
    .refill_i (refill_i),
    .inval_d  (inval_d),
    .inval_i  (inval_i),
    .victim_d (victim_d),
    .victim_i (victim_i),
    .base_d   (base_w[0]),
    .base_i   (base_w[1]),
    .mask_d   (clr_mask_d),
    .mask_i   (clr_mask_i)
);

// File: tb/tlb_lock_ctrl_bench.sv
module tlb_lock_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        refill_d = 1'b0, refill_i = 1'b0, inval_d = 1'b0, inval_i = 1'b0;
    logic [5:0]  victim_d, victim_i;
    logic [63:0] clr_mask_d, clr_mask_i;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [5:0]  m_base [2];
    logic [5:0]  m_vic  [2];
    logic        m_p    [2];
    logic [63:0] m_keep [2];

    always #2 clk = ~clk;

    tlb_lock_ctrl u_tlb_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .refill_d(refill_d), .refill_i(refill_i),
        .inval_d(inval_d), .inval_i(inval_i),
        .victim_d(victim_d), .victim_i(victim_i),
        .clr_mask_d(clr_mask_d), .clr_mask_i(clr_mask_i)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] word(int s);
        return {m_base[s], m_vic[s], 19'b0, m_p[s]};
    endfunction

    task automatic model_refill(int s);
        m_keep[s][m_vic[s]] = m_p[s];
        m_vic[s] = (m_vic[s] == 6'd63) ? m_base[s] : m_vic[s] + 6'd1;
    endtask

    task automatic check_side(int s, string req);
        @(negedge clk);
        reg_sel = 1'(s);
        #1;
        chk(req, {32'b0, reg_rdata}, {32'b0, word(s)});
        chk(req, {58'b0, (s == 0) ? victim_d : victim_i}, {58'b0, m_vic[s]});
    endtask

    task automatic write_reg(int s, logic [5:0] b, logic [5:0] v, logic p, logic [18:0] junk);
        @(negedge clk);
        reg_sel = 1'(s); reg_wr = 1'b1; reg_wdata = {b, v, junk, p};
        @(negedge clk);
        reg_wr = 1'b0;
        m_base[s] = b; m_vic[s] = v; m_p[s] = p;
    endtask

    task automatic refill(int s, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (s == 0) refill_d = 1'b1; else refill_i = 1'b1;
            model_refill(s);
        end
        @(negedge clk);
        refill_d = 1'b0; refill_i = 1'b0;
    endtask

    task automatic check_mask(int s, string req);
        @(negedge clk);
        if (s == 0) inval_d = 1'b1; else inval_i = 1'b1;
        #1;
        chk(req, (s == 0) ? clr_mask_d : clr_mask_i, ~m_keep[s]);
        chk("R9 other side mask", (s == 0) ? clr_mask_i : clr_mask_d, 64'b0);
        @(negedge clk);
        inval_d = 1'b0; inval_i = 1'b0;
        #1;
        chk("R8 mask idle", (s == 0) ? clr_mask_d : clr_mask_i, 64'b0);
    endtask

    task automatic t_reset();
        for (int s = 0; s < 2; s++) begin
            m_base[s] = '0; m_vic[s] = '0; m_p[s] = 1'b0; m_keep[s] = '0;
        end
        check_side(0, "R1 reset data");
        check_side(1, "R1 reset insn");
        chk("R1 mask d", clr_mask_d, 64'b0);
        chk("R1 mask i", clr_mask_i, 64'b0);
    endtask

    task automatic t_layout();
        write_reg(0, 6'd5, 6'd9, 1'b1, 19'h7ABCD);
        check_side(0, "R3 layout and ignored bits");
        check_side(1, "R2 insn untouched by data write");
        write_reg(1, 6'd33, 6'd40, 1'b0, 19'h12345);
        check_side(1, "R2 insn select");
        check_side(0, "R2 data untouched by insn write");
    endtask

    task automatic t_advance();
        refill(0, 3);
        check_side(0, "R4 three steps");
        repeat (4) @(negedge clk);
        check_side(0, "R4 hold when idle");
    endtask

    task automatic t_wrap();
        write_reg(1, 6'd60, 6'd62, 1'b0, 19'h0);
        refill(1, 1);
        check_side(1, "R4 step to 63");
        refill(1, 1);
        check_side(1, "R5 wrap to base");
    endtask

    task automatic t_write_wins();
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b1; refill_d = 1'b1;
        reg_wdata = {6'd7, 6'd20, 19'b0, 1'b0};
        m_keep[0][m_vic[0]] = m_p[0];
        @(negedge clk);
        reg_wr = 1'b0; refill_d = 1'b0;
        m_base[0] = 6'd7; m_vic[0] = 6'd20; m_p[0] = 1'b0;
        check_side(0, "R6 write beats refill");
        check_mask(0, "R6 capture at old index");
    endtask

    task automatic t_below_base();
        write_reg(0, 6'd62, 6'd1, 1'b0, 19'h0);
        refill(0, 62);
        check_side(0, "R7 reached 63 from below base");
        refill(0, 1);
        check_side(0, "R7 wrap to base");
        refill(0, 2);
        check_side(0, "R7 never below base after wrap");
    endtask

    task automatic t_preserve();
        write_reg(1, 6'd0, 6'd10, 1'b1, 19'h0);
        refill(1, 4);
        write_reg(1, 6'd0, 6'd20, 1'b0, 19'h0);
        refill(1, 2);
        check_mask(1, "R8 preserved entries spared");
        check_side(1, "R9 register unchanged by invalidate");
        check_mask(1, "R9 flags unchanged by invalidate");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_layout();
        t_advance();
        t_wrap();
        t_write_wins();
        t_below_base();
        t_preserve();
        finish_run();
    end
endmodule